// File: doc/BRIEF.md
# Pipelined Multiply-Adder with Run-Time Controls

This block multiplies several operand pairs in parallel lanes and folds the products into one wide result. Each lane registers its A and B operands, optionally widens A by adding B to it and multiplying by a coefficient picked from a fixed per-lane bank, and forms a product. A combining stage adds the first lane's product and adds or subtracts each of the others. It then either passes the sum on or adds it to a running total or to a fixed preload value.

Operand signedness, per-lane add/subtract, the coefficient mode, the coefficient index and the accumulate controls are all chosen every cycle. They travel down delay lines matched to the data, so each result is formed with the controls that came in with its operands. A chain select turns the lanes' A registers into a shift register: each lane then loads the A value held by the lane below it. The output latency is set by a product-register option and a count of extra output stages. Every register clears asynchronously and holds while the clock enable is low.

Top module: `rt_mult_add`

## Requirements
- R1: While `arst_n` is low, all registers are cleared at once: `result` reads 0 and `out_valid` reads 0, including when the clear is applied in the middle of a run.
- R2: With every mode input at 0, `result` equals the sum of `a_k*b_k` over all lanes (lane k uses bits [k*DW +: DW]). The result appears LAT = 2 + PROD_REG + EXTRA_LAT enabled clock edges after the operands are sampled (4 with the defaults).
- R3: `sign_sel`=1 treats every operand and coefficient as two's complement; `sign_sel`=0 treats them as unsigned.
- R4: Bit j of `sub_sel` set to 1 subtracts the product of lane j+1 instead of adding it. Lane 0's product is always added.
- R5: Every control input may change on every cycle, and each result uses the control values sampled on the same edge as its operands.
- R6: With accumulation off, `result` is the exact integer sum in two's complement over RES_W bits; the worst-case operands in both signedness modes do not overflow.
- R7: When `chain_sel` is 1 at an edge, lane k (k>=1) loads the A value lane k-1 held before that edge, and lane k's own A port has no effect. Lane 0 always loads its own port.
- R8: When `preadd_sel` is 1, lane k's product is `(A_k + B_k) * C_k[coef_sel]`, where C_k[i] = ((8k+i)*37+5) mod 2^DW is read under the same signedness as the operands.
- R9: `acc_en`=0 gives result = sum. `acc_en`=1 with `acc_load`=0 gives the sum plus the previous value of the first output register. `acc_en`=1 with `acc_load`=1 gives the sum plus PRELOAD (default 100). Accumulation wraps modulo 2^RES_W.
- R10: While `ce` is 0, no register changes: `result`, `out_valid` and all lane state hold.
- R11: `out_valid` repeats `in_valid` after LAT enabled edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous clear, active low |
| ce | input | 1 | Clock enable for every register |
| in_valid | input | 1 | Marks the operands as a real sample |
| a_in | input | N_MULT*DW | A operands, lane k in bits [k*DW +: DW] |
| b_in | input | N_MULT*DW | B operands, same lane packing |
| sign_sel | input | 1 | 1 = two's complement operands |
| sub_sel | input | N_MULT-1 | Bit j subtracts the product of lane j+1 |
| chain_sel | input | 1 | 1 = lane A registers shift from the lane below |
| preadd_sel | input | 1 | 1 = product is (A+B) times a bank coefficient |
| coef_sel | input | 3 | Coefficient index within each lane's bank of 8 |
| acc_en | input | 1 | Adds a feedback or preload term to the sum |
| acc_load | input | 1 | With acc_en, uses PRELOAD instead of feedback |
| out_valid | output | 1 | Valid flag aligned with result |
| result | output | RES_W | Signed combined result |

## Verification
A lane that decodes signedness or the coefficient wrongly corrupts `result` on the first affected sample, exactly LAT enabled edges after the operands went in. A control delay line of the wrong length shows up as results computed with a neighbouring sample's controls as soon as the controls change from cycle to cycle. A broken chain register gives a wrong sum one edge after chain mode starts. A feedback error stays in `result` for every later accumulating sample. A register that ignores `ce` or the clear shows up as soon as `ce` drops or the clear is applied.

// File: rtl/madd_pkg.sv
package madd_pkg;

  // Size of each lane's coefficient bank and its index width
  localparam int NCOEF = 8;
  localparam int COEF_SEL_W = $clog2(NCOEF);

  // Raw coefficient value for lane/index; callers truncate to data width
  function automatic int coef_raw(input int lane, input int idx);
    return (lane * NCOEF + idx) * 37 + 5;
  endfunction

endpackage

// File: rtl/madd_pipe.sv
module madd_pipe #(
  parameter int WIDTH = 1,
  parameter int DEPTH = 1
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             ce,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  generate
    if (DEPTH == 0) begin : g_wire
      assign q_o = d_i;
    end else begin : g_regs
      logic [WIDTH-1:0] stg [DEPTH];
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
          for (int i = 0; i < DEPTH; i++) stg[i] <= '0;
        end else if (ce) begin
          stg[0] <= d_i;
          for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
        end
      end
      assign q_o = stg[DEPTH-1];
    end
  endgenerate

endmodule

// File: rtl/madd_lane.sv
module madd_lane
  import madd_pkg::*;
#(
  parameter int DW       = 8,
  parameter int PROD_W   = 2 * DW + 2,
  parameter int LANE     = 0,
  parameter int PROD_REG = 1
) (
  input  logic                     clk,
  input  logic                     arst_n,
  input  logic                     ce,
  input  logic [DW-1:0]            a_port,
  input  logic [DW-1:0]            a_chain,
  input  logic                     chain_sel,
  input  logic [DW-1:0]            b_port,
  input  logic                     sign_s1,
  input  logic                     preadd_s1,
  input  logic [COEF_SEL_W-1:0]    coef_s1,
  output logic [DW-1:0]            a_q,
  output logic signed [PROD_W-1:0] prod_o
);

  logic [DW-1:0] b_q;

  // Widen an operand to the product width by sign or zero extension
  function automatic logic signed [PROD_W-1:0] widen(input logic [DW-1:0] v,
                                                     input logic sgn);
    if (sgn) return {{(PROD_W-DW){v[DW-1]}}, v};
    else     return {{(PROD_W-DW){1'b0}}, v};
  endfunction

  // Lane product: plain a*b, or (a+b)*coef in pre-add mode
  function automatic logic signed [PROD_W-1:0] lane_mul(
      input logic [DW-1:0] a, input logic [DW-1:0] b, input logic [DW-1:0] c,
      input logic sgn, input logic pre);
    logic signed [PROD_W-1:0] l_op, r_op;
    l_op = pre ? widen(a, sgn) + widen(b, sgn) : widen(a, sgn);
    r_op = pre ? widen(c, sgn) : widen(b, sgn);
    return l_op * r_op;
  endfunction

  // Input register; in chain mode A shifts from the lane below
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      a_q <= '0;
      b_q <= '0;
    end else if (ce) begin
      a_q <= chain_sel ? a_chain : a_port;
      b_q <= b_port;
    end
  end

  logic [DW-1:0]            coef_w;
  logic signed [PROD_W-1:0] prod_w;

  assign coef_w = DW'(coef_raw(LANE, int'(coef_s1)));
  assign prod_w = lane_mul(a_q, b_q, coef_w, sign_s1, preadd_s1);

  generate
    if (PROD_REG != 0) begin : g_preg
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n)  prod_o <= '0;
        else if (ce)  prod_o <= prod_w;
      end
    end else begin : g_pcomb
      assign prod_o = prod_w;
    end
  endgenerate

endmodule

// File: rtl/madd_sum_acc.sv
module madd_sum_acc #(
  parameter int N_MULT  = 4,
  parameter int PROD_W  = 18,
  parameter int RES_W   = 24,
  parameter int PRELOAD = 100
) (
  input  logic                     clk,
  input  logic                     arst_n,
  input  logic                     ce,
  input  logic [N_MULT*PROD_W-1:0] prods_i,
  input  logic [N_MULT-2:0]        sub_s,
  input  logic                     acc_en_s,
  input  logic                     acc_load_s,
  input  logic                     valid_s,
  output logic signed [RES_W-1:0]  sum_o,
  output logic [RES_W-1:0]         acc_q,
  output logic                     acc_valid
);

  localparam logic [RES_W-1:0] PRELOAD_V = RES_W'(PRELOAD);

  // Sign-extend one lane product to the result width
  function automatic logic signed [RES_W-1:0] grow(input logic [PROD_W-1:0] p);
    return {{(RES_W-PROD_W){p[PROD_W-1]}}, p};
  endfunction

  always_comb begin
    sum_o = grow(prods_i[0 +: PROD_W]);
    for (int k = 1; k < N_MULT; k++) begin
      if (sub_s[k-1]) sum_o = sum_o - grow(prods_i[k*PROD_W +: PROD_W]);
      else            sum_o = sum_o + grow(prods_i[k*PROD_W +: PROD_W]);
    end
  end

  logic [RES_W-1:0] acc_term;
  assign acc_term = !acc_en_s ? '0 : (acc_load_s ? PRELOAD_V : acc_q);

  // First output register doubles as the accumulator
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      acc_q     <= '0;
      acc_valid <= 1'b0;
    end else if (ce) begin
      acc_q     <= sum_o + acc_term;
      acc_valid <= valid_s;
    end
  end

endmodule

// File: rtl/rt_mult_add.sv
module rt_mult_add
  import madd_pkg::*;
#(
  parameter int N_MULT    = 4,
  parameter int DW        = 8,
  parameter int PROD_REG  = 1,
  parameter int EXTRA_LAT = 1,
  parameter int ACC_GUARD = 4,
  parameter int PRELOAD   = 100,
  localparam int PROD_W   = 2 * DW + 2,
  localparam int LOG_N    = $clog2(N_MULT),
  localparam int RES_W    = PROD_W + LOG_N + ACC_GUARD
) (
  input  logic                   clk,
  input  logic                   arst_n,
  input  logic                   ce,
  input  logic                   in_valid,
  input  logic [N_MULT*DW-1:0]   a_in,
  input  logic [N_MULT*DW-1:0]   b_in,
  input  logic                   sign_sel,
  input  logic [N_MULT-2:0]      sub_sel,
  input  logic                   chain_sel,
  input  logic                   preadd_sel,
  input  logic [COEF_SEL_W-1:0]  coef_sel,
  input  logic                   acc_en,
  input  logic                   acc_load,
  output logic                   out_valid,
  output logic [RES_W-1:0]       result
);

  localparam int S1_W  = 2 + COEF_SEL_W;
  localparam int SUM_W = (N_MULT - 1) + 3;

  // Named internal events for the checker
  logic                     sign_s1, preadd_s1;
  logic [COEF_SEL_W-1:0]    coef_s1;
  logic [N_MULT-2:0]        sub_s;
  logic                     acc_en_s, acc_load_s, valid_s;
  logic [N_MULT*DW-1:0]     a_q_flat;
  logic [N_MULT*PROD_W-1:0] prod_flat;
  logic signed [RES_W-1:0]  sum_w;
  logic [RES_W-1:0]         acc_q;
  logic                     acc_valid;

  // Controls used by the lanes: delayed to line up with the input register
  madd_pipe #(.WIDTH(S1_W), .DEPTH(1)) u_ctl_s1 (
    .clk(clk), .arst_n(arst_n), .ce(ce),
    .d_i({sign_sel, preadd_sel, coef_sel}),
    .q_o({sign_s1, preadd_s1, coef_s1})
  );

  // Controls used by the combining stage: delayed past the product register too
  madd_pipe #(.WIDTH(SUM_W), .DEPTH(1 + PROD_REG)) u_ctl_sum (
    .clk(clk), .arst_n(arst_n), .ce(ce),
    .d_i({sub_sel, acc_en, acc_load, in_valid}),
    .q_o({sub_s, acc_en_s, acc_load_s, valid_s})
  );

  generate
    for (genvar k = 0; k < N_MULT; k++) begin : g_lane
      logic [DW-1:0] chain_src;
      if (k == 0) begin : g_head
        assign chain_src = a_in[0 +: DW];
      end else begin : g_link
        assign chain_src = a_q_flat[(k-1)*DW +: DW];
      end
      madd_lane #(.DW(DW), .PROD_W(PROD_W), .LANE(k), .PROD_REG(PROD_REG)) u_lane (
        .clk(clk), .arst_n(arst_n), .ce(ce),
        .a_port(a_in[k*DW +: DW]),
        .a_chain(chain_src),
        .chain_sel(chain_sel),
        .b_port(b_in[k*DW +: DW]),
        .sign_s1(sign_s1),
        .preadd_s1(preadd_s1),
        .coef_s1(coef_s1),
        .a_q(a_q_flat[k*DW +: DW]),
        .prod_o(prod_flat[k*PROD_W +: PROD_W])
      );
    end
  endgenerate

  madd_sum_acc #(.N_MULT(N_MULT), .PROD_W(PROD_W), .RES_W(RES_W), .PRELOAD(PRELOAD)) u_sum (
    .clk(clk), .arst_n(arst_n), .ce(ce),
    .prods_i(prod_flat),
    .sub_s(sub_s),
    .acc_en_s(acc_en_s),
    .acc_load_s(acc_load_s),
    .valid_s(valid_s),
    .sum_o(sum_w),
    .acc_q(acc_q),
    .acc_valid(acc_valid)
  );

  // Extra latency stages after the first output register
  madd_pipe #(.WIDTH(RES_W + 1), .DEPTH(EXTRA_LAT)) u_out (
    .clk(clk), .arst_n(arst_n), .ce(ce),
    .d_i({acc_valid, acc_q}),
    .q_o({out_valid, result})
  );

endmodule

// File: rtl/rt_mult_add_chk.sv
module rt_mult_add_chk #(
  parameter int N_MULT  = 4,
  parameter int DW      = 8,
  parameter int PROD_W  = 18,
  parameter int LOG_N   = 2,
  parameter int RES_W   = 24,
  parameter int PRELOAD = 100
) (
  input logic                 clk,
  input logic                 arst_n,
  input logic                 ce,
  input logic                 chain_sel,
  input logic [N_MULT*DW-1:0] a_q_flat,
  input logic [RES_W-1:0]     sum_w,
  input logic                 acc_en_s,
  input logic                 acc_load_s,
  input logic                 valid_s,
  input logic [RES_W-1:0]     acc_q,
  input logic                 acc_valid,
  input logic [RES_W-1:0]     result,
  input logic                 out_valid
);

  localparam int TOP = PROD_W + LOG_N - 1;
  localparam logic [RES_W-1:0] PRE_V = RES_W'(PRELOAD);

  // R10: a disabled clock freezes outputs and lane state
  a_r10_hold: assert property (@(posedge clk) disable iff (!arst_n)
    !ce |=> $stable(result) && $stable(out_valid) && $stable(a_q_flat));

  // R6: the combined sum never reaches the guard bits
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!arst_n)
    (&sum_w[RES_W-1:TOP]) || !(|sum_w[RES_W-1:TOP]));

  // R9: no accumulation loads the plain sum
  a_r9_plain_sum: assert property (@(posedge clk) disable iff (!arst_n)
    ce && !acc_en_s |=> acc_q == $past(sum_w));

  // R9: preload replaces the feedback term
  a_r9_preload: assert property (@(posedge clk) disable iff (!arst_n)
    ce && acc_en_s && acc_load_s |=> acc_q == $past(sum_w) + PRE_V);

  // R11: valid moves into the first output register with its data
  a_r11_valid_step: assert property (@(posedge clk) disable iff (!arst_n)
    ce |=> acc_valid == $past(valid_s));

  generate
    for (genvar k = 1; k < N_MULT; k++) begin : g_chain
      // R7: chain mode shifts A registers one lane up
      a_r7_chain_shift: assert property (@(posedge clk) disable iff (!arst_n)
        ce && chain_sel |=> a_q_flat[k*DW +: DW] == $past(a_q_flat[(k-1)*DW +: DW]));
    end
  endgenerate

endmodule

bind rt_mult_add rt_mult_add_chk #(
  .N_MULT(N_MULT), .DW(DW), .PROD_W(PROD_W), .LOG_N(LOG_N),
  .RES_W(RES_W), .PRELOAD(PRELOAD)
) u_chk (
  .clk(clk), .arst_n(arst_n), .ce(ce), .chain_sel(chain_sel),
  .a_q_flat(a_q_flat), .sum_w(sum_w), .acc_en_s(acc_en_s),
  .acc_load_s(acc_load_s), .valid_s(valid_s), .acc_q(acc_q),
  .acc_valid(acc_valid), .result(result), .out_valid(out_valid)
);

// File: tb/rt_mult_add_tb_top.sv
module rt_mult_add_tb_top;

  localparam int N   = 4;
  localparam int W   = 8;
  localparam int PR  = 1;
  localparam int XL  = 1;
  localparam int PRE = 100;
  localparam int RW  = (2 * W + 2) + $clog2(N) + 4;
  localparam int LAT = 2 + PR + XL;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          arst_n, ce, in_valid, sign_sel, chain_sel, preadd_sel;
  logic          acc_en, acc_load;
  logic [N*W-1:0] a_in, b_in;
  logic [N-2:0]   sub_sel;
  logic [2:0]     coef_sel;
  logic           out_valid;
  logic [RW-1:0]  result;

  rt_mult_add #(.N_MULT(N), .DW(W), .PROD_REG(PR), .EXTRA_LAT(XL),
                .ACC_GUARD(4), .PRELOAD(PRE)) dut_i (
    .clk(clk), .arst_n(arst_n), .ce(ce), .in_valid(in_valid),
    .a_in(a_in), .b_in(b_in), .sign_sel(sign_sel), .sub_sel(sub_sel),
    .chain_sel(chain_sel), .preadd_sel(preadd_sel), .coef_sel(coef_sel),
    .acc_en(acc_en), .acc_load(acc_load), .out_valid(out_valid), .result(result)
  );

  // Reference model state
  logic [W-1:0]  a_hold [N];
  logic [RW-1:0] exp_res [$];
  bit            exp_val [$];
  logic [RW-1:0] run_tot;
  int vectors = 0, miscompares = 0;
  string tag = "R1";
  bit finished = 0;

  function automatic longint as_num(input logic [W-1:0] v, input bit s);
    if (s && v[W-1]) return longint'(v) - (longint'(1) << W);
    return longint'(v);
  endfunction

  function automatic logic [W-1:0] bank(input int lane, input int idx);
    int v;
    v = 37 * idx + 296 * lane + 5;
    return v[W-1:0];
  endfunction

  task automatic model_clear();
    exp_res.delete(); exp_val.delete();
    for (int i = 0; i < LAT; i++) begin exp_res.push_back('0); exp_val.push_back(0); end
    for (int k = 0; k < N; k++) a_hold[k] = '0;
    run_tot = '0;
  endtask

  // What the coming clock edge does to the design
  task automatic model_edge();
    logic [W-1:0] nxt [N];
    longint tot, pk;
    logic [RW-1:0] r;
    if (!arst_n || !ce) return;
    for (int k = 0; k < N; k++)
      nxt[k] = (chain_sel && k > 0) ? a_hold[k-1] : a_in[k*W +: W];
    for (int k = 0; k < N; k++) a_hold[k] = nxt[k];
    tot = 0;
    for (int k = 0; k < N; k++) begin
      if (preadd_sel)
        pk = (as_num(a_hold[k], sign_sel) + as_num(b_in[k*W +: W], sign_sel))
             * as_num(bank(k, int'(coef_sel)), sign_sel);
      else
        pk = as_num(a_hold[k], sign_sel) * as_num(b_in[k*W +: W], sign_sel);
      if (k > 0 && sub_sel[k-1]) tot -= pk; else tot += pk;
    end
    if (acc_en) tot += acc_load ? longint'(PRE) : longint'(run_tot);
    r = RW'(tot);
    run_tot = r;
    void'(exp_res.pop_front()); void'(exp_val.pop_front());
    exp_res.push_back(r); exp_val.push_back(in_valid);
  endtask

  task automatic compare();
    logic [RW-1:0] er;
    bit ev;
    er = arst_n ? exp_res[0] : '0;
    ev = arst_n ? exp_val[0] : 1'b0;
    vectors++;
    if (result !== er) begin
      miscompares++;
      $display("FAIL %s result got %h expected %h", tag, result, er);
    end
    if (out_valid !== ev) begin
      miscompares++;
      $display("FAIL %s/R11 out_valid got %b expected %b", tag, out_valid, ev);
    end
  endtask

  task automatic rnd_ops(input bit extreme);
    for (int k = 0; k < N; k++) begin
      if (extreme) begin
        a_in[k*W +: W] = ($urandom_range(0, 1) == 1) ? {W{1'b1}} : {1'b1, {(W-1){1'b0}}};
        b_in[k*W +: W] = ($urandom_range(0, 1) == 1) ? {W{1'b1}} : {1'b1, {(W-1){1'b0}}};
      end else begin
        a_in[k*W +: W] = W'($urandom);
        b_in[k*W +: W] = W'($urandom);
      end
    end
  endtask

  task automatic cycle();
    @(negedge clk);
    compare();
  endtask

  task automatic run_phase(input int ph, input int n);
    for (int c = 0; c < n; c++) begin
      cycle();
      ce = 1; sign_sel = 0; sub_sel = '0; chain_sel = 0; preadd_sel = 0;
      coef_sel = '0; acc_en = 0; acc_load = 0; in_valid = 1;
      rnd_ops(ph == 3);
      case (ph)
        0: tag = "R2";
        1: begin tag = "R3"; sign_sel = 1; end
        2: begin tag = "R4/R5"; sign_sel = 1'($urandom); sub_sel = (N-1)'($urandom);
                 in_valid = 1'($urandom); end
        3: begin tag = "R6"; sign_sel = 1'($urandom); sub_sel = (N-1)'($urandom); end
        4: begin tag = "R7"; chain_sel = ($urandom_range(0, 3) != 0);
                 sign_sel = 1'($urandom); sub_sel = (N-1)'($urandom); end
        5: begin tag = "R8"; preadd_sel = 1'($urandom); coef_sel = 3'($urandom);
                 sign_sel = 1'($urandom); sub_sel = (N-1)'($urandom); end
        6: begin tag = "R9"; acc_en = 1'($urandom); acc_load = ($urandom_range(0, 3) == 0);
                 sign_sel = 1'($urandom); end
        default: begin tag = "R10"; ce = ($urandom_range(0, 2) != 0);
                 in_valid = 1'($urandom); sign_sel = 1'($urandom);
                 sub_sel = (N-1)'($urandom); chain_sel = 1'($urandom);
                 preadd_sel = 1'($urandom); coef_sel = 3'($urandom);
                 acc_en = 1'($urandom); acc_load = 1'($urandom); end
      endcase
      model_edge();
    end
  endtask

  initial begin
    arst_n = 0; ce = 1; in_valid = 0; sign_sel = 0; sub_sel = '0; chain_sel = 0;
    preadd_sel = 0; coef_sel = '0; acc_en = 0; acc_load = 0; a_in = '0; b_in = '0;
    model_clear();
    tag = "R1";
    for (int i = 0; i < 3; i++) cycle();
    arst_n = 1;
    for (int ph = 0; ph < 8; ph++) run_phase(ph, 400);
    // R1: clear in the middle of busy traffic
    cycle();
    tag = "R1";
    arst_n = 0;
    model_clear();
    for (int i = 0; i < 3; i++) cycle();
    arst_n = 1;
    run_phase(7, 300);
    cycle();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog %s no completion got 0 expected 1", tag);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule